// File: doc/BRIEF.md
# Operand-Affinity Cluster Steering Unit

This block picks, at dispatch time, the execution cluster that a micro-op is sent to. For each of up to four source operands it receives a valid bit, an in-flight flag and the id of the cluster that produces the operand's value. The in-flight flag means the producer either still waits to execute in that cluster or has a result still on that cluster's bypass network. Each cluster gets a score, which is the number of in-flight operands it produces. The op goes to the highest-scoring cluster among those it may legally use.

A cluster is legal when its bit is set both in the op's capability mask (the cluster has a unit that can run the op) and in a per-op restriction mask (for example, limits on which register file the cluster can write). The decision is made combinationally in the request cycle and is registered. It appears on the outputs in the next cycle with a one-cycle valid pulse, and it stays there until the next request, so a steered op never changes cluster. When no cluster is legal, the block raises a flag and reports cluster 0.

Top module: `steer_unit`

## Requirements
- R1: During and right after reset, outValid is 0, outCluster is 0 and outNoLegal is 0.
- R2: A cluster's score is the number of operands i with srcValid[i]=1, srcInFlight[i]=1 and a producer id equal to that cluster. Operand i's producer id is srcCluster[2i+1:2i]. The chosen cluster has the highest score among the legal clusters, and a score of 4 is supported.
- R3: An operand with srcValid=0, or with srcInFlight=0 (already ready), adds nothing to any score.
- R4: Cluster c is eligible only if capMask[c]=1. A higher-scoring cluster with capMask[c]=0 is never chosen.
- R5: Cluster c is eligible only if restrictMask[c]=1. This further limits the clusters allowed by capMask.
- R6: When several eligible clusters share the highest score, the lowest-numbered one is chosen. This includes the case where every score is zero.
- R7: If capMask AND restrictMask is zero, outNoLegal is 1 and outCluster is 0. Otherwise outNoLegal is 0.
- R8: When reqValid is 1 at a rising edge, the decision for that cycle's inputs appears on outCluster and outNoLegal after that edge, and outValid is 1 for exactly that one following cycle.
- R9: While reqValid is 0, outCluster and outNoLegal keep their last values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A micro-op is being steered this cycle |
| srcValid | input | 4 | Operand i is a real source |
| srcInFlight | input | 4 | Operand i's producer is pending or on the bypass network |
| srcCluster | input | 8 | Producer cluster id of operand i in bits [2i+1:2i] |
| capMask | input | 4 | Clusters able to execute the op |
| restrictMask | input | 4 | Extra per-op cluster restriction |
| outValid | output | 1 | One-cycle pulse marking a new decision |
| outCluster | output | 2 | Chosen cluster id |
| outNoLegal | output | 1 | No cluster is legal for the op |

## Verification
The scoring is tested with operand sets that give a clear majority, a full score of four, and mixes of ready, invalid and in-flight operands. These separate correct counting from counting every valid operand or ignoring operand positions. Masking is tested where the best-scoring cluster is removed first by the capability mask and then by the restriction mask, which shows each mask is applied on its own. Ties between non-adjacent clusters, an all-zero score with only high clusters legal, and disjoint masks test the fallback rules. A request followed by idle cycles with changed inputs tests the valid pulse and that the decision is held.

// File: rtl/steer_pkg.sv
package steer_pkg;
  // Strobes driven by the control toward the datapath
  typedef struct packed {
    logic loadResult; // capture the combinational decision
    logic validNext;  // next value of the output valid pulse
  } steerStrobes_t;
endpackage

// File: rtl/steer_score.sv
module steer_score #(
  parameter int unsigned NUM_CLUSTERS = 4,
  parameter int unsigned NUM_SRCS     = 4,
  parameter int unsigned SCORE_W      = 3,
  parameter int unsigned CID_W        = 2
) (
  input  logic [NUM_SRCS-1:0]              srcValid,
  input  logic [NUM_SRCS-1:0]              srcInFlight,
  input  logic [NUM_SRCS*CID_W-1:0]        srcCluster,
  output logic [NUM_CLUSTERS*SCORE_W-1:0]  scores
);
  // Operands that can contribute to some cluster's score
  logic [NUM_SRCS-1:0] srcLive;
  assign srcLive = srcValid & srcInFlight;

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : gScore
    logic [SCORE_W-1:0] count;
    always_comb begin
      count = '0;
      for (int s = 0; s < NUM_SRCS; s++) begin
        if (srcLive[s] && (srcCluster[s*CID_W +: CID_W] == CID_W'(c)))
          count = count + SCORE_W'(1);
      end
    end
    assign scores[c*SCORE_W +: SCORE_W] = count;
  end
endmodule

// File: rtl/steer_datapath.sv
module steer_datapath
  import steer_pkg::*;
#(
  parameter int unsigned NUM_CLUSTERS = 4,
  parameter int unsigned NUM_SRCS     = 4,
  parameter int unsigned SCORE_W      = 3,
  parameter int unsigned CID_W        = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  steerStrobes_t              strobes,
  input  logic [NUM_SRCS-1:0]        srcValid,
  input  logic [NUM_SRCS-1:0]        srcInFlight,
  input  logic [NUM_SRCS*CID_W-1:0]  srcCluster,
  input  logic [NUM_CLUSTERS-1:0]    capMask,
  input  logic [NUM_CLUSTERS-1:0]    restrictMask,
  output logic                       outValid,
  output logic [CID_W-1:0]           outCluster,
  output logic                       outNoLegal
);
  logic [NUM_CLUSTERS*SCORE_W-1:0] scores;
  logic [SCORE_W-1:0]              scoreArr [NUM_CLUSTERS];
  logic [NUM_CLUSTERS-1:0]         eligible;
  logic                            found;
  logic [CID_W-1:0]                bestId;
  logic [SCORE_W-1:0]              bestScore;
  logic [NUM_CLUSTERS-1:0]         beaten;

  steer_score #(
    .NUM_CLUSTERS(NUM_CLUSTERS), .NUM_SRCS(NUM_SRCS),
    .SCORE_W(SCORE_W), .CID_W(CID_W)
  ) uScore (
    .srcValid(srcValid), .srcInFlight(srcInFlight),
    .srcCluster(srcCluster), .scores(scores)
  );

  assign eligible = capMask & restrictMask;

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : gUnpack
    assign scoreArr[c] = scores[c*SCORE_W +: SCORE_W];
    // Eligible cluster with a strictly higher score than the pick
    assign beaten[c]   = eligible[c] && (scoreArr[c] > bestScore);
  end

  // Ascending scan, strict compare: ties stay with the lower id
  always_comb begin
    found     = 1'b0;
    bestId    = '0;
    bestScore = '0;
    for (int c = 0; c < NUM_CLUSTERS; c++) begin
      if (eligible[c] && (!found || scoreArr[c] > bestScore)) begin
        found     = 1'b1;
        bestId    = CID_W'(c);
        bestScore = scoreArr[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outCluster <= '0;
      outNoLegal <= 1'b0;
    end else begin
      outValid <= strobes.validNext;
      if (strobes.loadResult) begin
        outCluster <= found ? bestId : '0;
        outNoLegal <= !found;
      end
    end
  end

  AST_NO_BETTER_CLUSTER: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadResult |-> (beaten == '0)); // R2

  AST_PICK_IS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.loadResult) && !outNoLegal) |->
      ((($past(eligible)) >> outCluster) & NUM_CLUSTERS'(1)) != '0); // R4

  AST_NOLEGAL_ZERO_ID: assert property (@(posedge clk) disable iff (!rstN)
    outNoLegal |-> (outCluster == '0)); // R7

  AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadResult |=> ($stable(outCluster) && $stable(outNoLegal))); // R9
endmodule

// File: rtl/steer_control.sv
module steer_control
  import steer_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          outValid,
  output steerStrobes_t strobes
);
  always_comb begin
    strobes.loadResult = reqValid && rstN;
    strobes.validNext  = reqValid && rstN;
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid); // R8

  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid); // R8
endmodule

// File: rtl/steer_unit.sv
module steer_unit
  import steer_pkg::*;
#(
  parameter int unsigned NUM_CLUSTERS = 4,
  parameter int unsigned NUM_SRCS     = 4,
  parameter int unsigned SCORE_W      = 3,
  localparam int unsigned CID_W       = $clog2(NUM_CLUSTERS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [NUM_SRCS-1:0]        srcValid,
  input  logic [NUM_SRCS-1:0]        srcInFlight,
  input  logic [NUM_SRCS*CID_W-1:0]  srcCluster,
  input  logic [NUM_CLUSTERS-1:0]    capMask,
  input  logic [NUM_CLUSTERS-1:0]    restrictMask,
  output logic                       outValid,
  output logic [CID_W-1:0]           outCluster,
  output logic                       outNoLegal
);
  steerStrobes_t strobes;

  steer_control uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .outValid(outValid), .strobes(strobes)
  );

  steer_datapath #(
    .NUM_CLUSTERS(NUM_CLUSTERS), .NUM_SRCS(NUM_SRCS),
    .SCORE_W(SCORE_W), .CID_W(CID_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .srcValid(srcValid), .srcInFlight(srcInFlight), .srcCluster(srcCluster),
    .capMask(capMask), .restrictMask(restrictMask),
    .outValid(outValid), .outCluster(outCluster), .outNoLegal(outNoLegal)
  );
endmodule

// File: tb/steer_unit_test.sv
module steer_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [3:0] srcValid = '0, srcInFlight = '0, capMask = '0, restrictMask = '0;
  logic [7:0] srcCluster = '0;
  logic       outValid, outNoLegal;
  logic [1:0] outCluster;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  steer_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .srcValid(srcValid), .srcInFlight(srcInFlight), .srcCluster(srcCluster),
    .capMask(capMask), .restrictMask(restrictMask),
    .outValid(outValid), .outCluster(outCluster), .outNoLegal(outNoLegal)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cluster ids for operands 3..0
  function automatic logic [7:0] ids(int a3, int a2, int a1, int a0);
    return {2'(a3), 2'(a2), 2'(a1), 2'(a0)};
  endfunction

  // Apply one request at negedge, then sample at the following negedge
  task automatic steer(logic [3:0] v, logic [3:0] f, logic [7:0] cl,
                       logic [3:0] cap, logic [3:0] rs);
    @(negedge clk);
    reqValid = 1'b1; srcValid = v; srcInFlight = f; srcCluster = cl;
    capMask = cap; restrictMask = rs;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic tReset();
    check("R1 valid", 4'(outValid), 0);
    check("R1 cluster", 4'(outCluster), 0);
    check("R1 nolegal", 4'(outNoLegal), 0);
  endtask

  task automatic tMajority();
    steer(4'b0111, 4'b0111, ids(0, 1, 2, 2), 4'hF, 4'hF);
    check("R2 majority", 4'(outCluster), 2);
    check("R8 pulse", 4'(outValid), 1);
    steer(4'hF, 4'hF, ids(3, 3, 3, 3), 4'hF, 4'hF);
    check("R2 score four", 4'(outCluster), 3);
  endtask

  task automatic tNotInFlight();
    steer(4'hF, 4'b0001, ids(3, 3, 3, 1), 4'hF, 4'hF);
    check("R3 ready ignored", 4'(outCluster), 1);
    steer(4'b0001, 4'hF, ids(2, 2, 2, 1), 4'hF, 4'hF);
    check("R3 invalid ignored", 4'(outCluster), 1);
  endtask

  task automatic tMasks();
    steer(4'hF, 4'hF, ids(2, 2, 3, 1), 4'b1011, 4'hF);
    check("R4 capability", 4'(outCluster), 1);
    steer(4'hF, 4'hF, ids(2, 2, 3, 1), 4'hF, 4'b0111);
    check("R5 restriction", 4'(outCluster), 2);
    steer(4'hF, 4'hF, ids(2, 2, 3, 3), 4'hF, 4'b0011);
    check("R5 restrict zero score", 4'(outCluster), 0);
  endtask

  task automatic tTies();
    steer(4'b0011, 4'b0011, ids(0, 0, 3, 1), 4'hF, 4'hF);
    check("R6 tie", 4'(outCluster), 1);
    steer(4'h0, 4'h0, ids(0, 0, 0, 0), 4'b1100, 4'hF);
    check("R6 all zero", 4'(outCluster), 2);
    check("R7 legal flag low", 4'(outNoLegal), 0);
  endtask

  task automatic tNoLegal();
    steer(4'hF, 4'hF, ids(1, 1, 1, 1), 4'b0011, 4'b1100);
    check("R7 nolegal", 4'(outNoLegal), 1);
    check("R7 zero id", 4'(outCluster), 0);
  endtask

  task automatic tHold();
    steer(4'hF, 4'hF, ids(3, 3, 3, 0), 4'hF, 4'hF);
    check("R8 decision", 4'(outCluster), 3);
    // inputs change with reqValid low
    srcCluster = ids(1, 1, 1, 1); capMask = 4'b0010;
    @(negedge clk);
    check("R8 pulse ends", 4'(outValid), 0);
    check("R9 held cluster", 4'(outCluster), 3);
    capMask = 4'h0;
    @(negedge clk);
    check("R9 held nolegal", 4'(outNoLegal), 0);
    check("R9 held cluster 2", 4'(outCluster), 3);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMajority();
    tNotInFlight();
    tMasks();
    tTies();
    tNoLegal();
    tHold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule